// File: doc/BRIEF.md
# Wide Modular Reduction Unit

This register-mapped unit computes the remainder of a 512-bit operand divided by a 256-bit modulus. Software writes the sixteen operand words and the eight modulus words through a simple word-wide write port. It puts the unit into compute mode and pulses `start`. It then waits for the one-cycle `done` pulse and reads eight result words back through a combinational read port. In every buffer, word 0 holds the most significant 32 bits.

Before the first computation, software must bring the unit up. It writes the reset code to the mode word and polls the ready bit of the status word until that bit reads 1. The datapath uses restoring shift-and-subtract. It consumes one operand bit per clock, so the remainder of a nonzero modulus is ready a fixed 512 cycles after the start edge. A zero modulus is reported as an error rather than computed.

Top module: `modred_unit`

## Requirements
- R1: Word address map: 0 = mode, 1 = status, 2..17 = operand words, 18..25 = modulus words, 26..33 = result words. In every buffer, word 0 is the most significant 32 bits. Any other read address returns 0.
- R2: After `rst`, every mapped word reads 0 (mode = reset, status = 0, buffers and result cleared) and `done` is low.
- R3: Writing 0 to the mode word clears ready, busy, error and the result. Status bit 0 (ready) then reads 1 exactly 4 cycles after the write edge.
- R4: The mode word accepts only the codes 0 (reset) and 1 (compute). Any other value leaves it unchanged. The mode word reads back its code in bit 0.
- R5: `start` is accepted only when ready is 1, mode is compute and no computation is running. Otherwise it produces no `done` pulse and sets no busy bit.
- R6: For a nonzero modulus, the result equals operand mod modulus, and any unused high result words read 0.
- R7: After an accepted start with a nonzero modulus, status bit 1 (busy) is high and `done` pulses for exactly one cycle 512 cycles after the start edge. Busy then falls.
- R8: An accepted start with a zero modulus sets status bit 2 (error), forces the result to 0 and pulses `done` in the cycle right after the start edge.
- R9: Writes to operand or modulus words while busy is high are ignored.
- R10: Writes to the status word or to the result words have no effect.
- R11: An accepted start with a nonzero modulus clears a previously set error bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Word write strobe |
| wr_addr | input | 6 | Word write address |
| wr_data | input | 32 | Word write data |
| rd_addr | input | 6 | Word read address |
| rd_data | output | 32 | Word read data (combinational) |
| start | input | 1 | Start strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench goes after several edge cases:
- A modulus far narrower than the operand (modulus 3). A design that dropped the final shifted bit or compared one bit short would return 0 or 1 instead of 2.
- Operands with the upper six words zero, and operands smaller than the modulus. Here a word-order swap would scramble the result.
- An all-ones operand against an all-ones modulus. This exposes a missing borrow bit in the 257-bit trial subtraction.
- Buffer writes and a second `start` during a running computation. A design without lockout would corrupt the remainder or restart the count.
- A zero modulus, an early `start` before the ready handshake and an illegal mode code. Each of these must leave the unit quiet or flag it, rather than hang or compute garbage.

// File: rtl/modred_pkg.sv
`timescale 1ns/1ps
package modred_pkg;
    parameter int WORD_W     = 32;
    parameter int OP_WORDS   = 16;
    parameter int MOD_WORDS  = 8;
    parameter int ADDR_W     = 6;
    parameter int RESET_WAIT = 4;

    localparam int MODE_OFS = 0;
    localparam int STAT_OFS = 1;
    localparam int OP_BASE  = 2;

    localparam int CODE_RESET   = 0;
    localparam int CODE_COMPUTE = 1;

    typedef enum logic {
        MODE_RESET   = 1'b0,
        MODE_COMPUTE = 1'b1
    } mode_e;

    typedef struct packed {
        logic error;
        logic busy;
        logic ready;
    } stat_t;

    // bit position of the low end of word w in a big-endian word array
    function automatic int word_lsb(input int w, input int nwords, input int ww);
        return (nwords - 1 - w) * ww;
    endfunction
endpackage

// File: rtl/modred_regfile.sv
`timescale 1ns/1ps
module modred_regfile
    import modred_pkg::*;
#(
    parameter int W   = WORD_W,
    parameter int OPW = OP_WORDS,
    parameter int MDW = MOD_WORDS,
    parameter int AW  = ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lock,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [OPW*W-1:0]  operand,
    output logic [MDW*W-1:0]  modulus
);
    localparam int MOD_BASE = OP_BASE + OPW;

    generate
        for (genvar g = 0; g < OPW; g++) begin : g_op
            localparam logic [AW-1:0] ADDR = AW'(OP_BASE + g);
            logic [W-1:0] word_q;
            always_ff @(posedge clk) begin
                if (rst)
                    word_q <= '0;
                else if (wr_en && !lock && wr_addr == ADDR)
                    word_q <= wr_data;
            end
            assign operand[word_lsb(g, OPW, W) +: W] = word_q;
        end
        for (genvar g = 0; g < MDW; g++) begin : g_mod
            localparam logic [AW-1:0] ADDR = AW'(MOD_BASE + g);
            logic [W-1:0] word_q;
            always_ff @(posedge clk) begin
                if (rst)
                    word_q <= '0;
                else if (wr_en && !lock && wr_addr == ADDR)
                    word_q <= wr_data;
            end
            assign modulus[word_lsb(g, MDW, W) +: W] = word_q;
        end
    endgenerate

    // R9: buffers frozen while a computation runs
    a_r9_operand_frozen: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(operand));
    a_r9_modulus_frozen: assert property (@(posedge clk) disable iff (rst)
        lock |=> $stable(modulus));
endmodule

// File: rtl/modred_ctrl.sv
`timescale 1ns/1ps
module modred_ctrl
    import modred_pkg::*;
#(
    parameter int OP_BITS = OP_WORDS * WORD_W,
    parameter int WAIT    = RESET_WAIT
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  mode_clr,
    input  logic  mode_set,
    input  logic  start,
    input  logic  mod_zero,
    output mode_e mode,
    output stat_t stat,
    output logic  done,
    output logic  load,
    output logic  zero_res,
    output logic  step,
    output logic  last
);
    localparam int CW = $clog2(OP_BITS);
    localparam int WW = $clog2(WAIT + 1);

    logic          waiting;
    logic [WW-1:0] wcnt;
    logic [CW-1:0] icnt;
    logic          accept;

    assign accept   = start && stat.ready && (mode == MODE_COMPUTE) && !stat.busy;
    assign load     = accept && !mod_zero;
    assign zero_res = accept && mod_zero;
    assign step     = stat.busy;
    assign last     = stat.busy && (icnt == CW'(OP_BITS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            mode    <= MODE_RESET;
            stat    <= '0;
            waiting <= 1'b0;
            wcnt    <= '0;
            icnt    <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (mode_clr) begin
                mode       <= MODE_RESET;
                stat       <= '0;
                waiting    <= 1'b1;
                wcnt       <= WW'(WAIT - 1);
            end else begin
                if (mode_set)
                    mode <= MODE_COMPUTE;
                if (waiting) begin
                    if (wcnt == '0) begin
                        stat.ready <= 1'b1;
                        waiting    <= 1'b0;
                    end else begin
                        wcnt <= wcnt - 1'b1;
                    end
                end
                if (accept) begin
                    if (mod_zero) begin
                        stat.error <= 1'b1;
                        done       <= 1'b1;
                    end else begin
                        stat.error <= 1'b0;
                        stat.busy  <= 1'b1;
                        icnt       <= '0;
                    end
                end else if (stat.busy) begin
                    icnt <= icnt + 1'b1;
                    if (last) begin
                        stat.busy <= 1'b0;
                        done      <= 1'b1;
                    end
                end
            end
        end
    end

    // R7: completion is a single-cycle pulse
    a_r7_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R7: busy ends only with done, or through a mode reset
    a_r7_busy_ends_done: assert property (@(posedge clk) disable iff (rst)
        $fell(stat.busy) |-> (done || $past(mode_clr)));
    // R5: a run begins only from ready in compute mode
    a_r5_start_gated: assert property (@(posedge clk) disable iff (rst)
        $rose(stat.busy) |-> ($past(stat.ready) && $past(mode == MODE_COMPUTE)));
    // R3: ready stays low during the reset wait
    a_r3_wait_not_ready: assert property (@(posedge clk) disable iff (rst)
        waiting |-> !stat.ready);
endmodule

// File: rtl/modred_core.sv
`timescale 1ns/1ps
module modred_core
    import modred_pkg::*;
#(
    parameter int OB = OP_WORDS * WORD_W,
    parameter int MB = MOD_WORDS * WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          zero_res,
    input  logic          load,
    input  logic          step,
    input  logic          last,
    input  logic [OB-1:0] operand,
    input  logic [MB-1:0] modulus,
    output logic [MB-1:0] result
);
    logic [MB-1:0] rem_q;
    logic [OB-1:0] sh_q;
    logic [MB:0]   trial;
    logic [MB:0]   diff;
    logic [MB-1:0] rem_nxt;

    always_comb begin
        trial   = {rem_q, sh_q[OB-1]};
        diff    = trial - {1'b0, modulus};
        rem_nxt = (trial >= {1'b0, modulus}) ? diff[MB-1:0] : trial[MB-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rem_q  <= '0;
            sh_q   <= '0;
            result <= '0;
        end else if (clear || zero_res) begin
            result <= '0;
        end else if (load) begin
            rem_q <= '0;
            sh_q  <= operand;
        end else if (step) begin
            rem_q <= rem_nxt;
            sh_q  <= {sh_q[OB-2:0], 1'b0};
            if (last)
                result <= rem_nxt;
        end
    end

    // R6: partial remainder always below the modulus while iterating
    a_r6_rem_bound: assert property (@(posedge clk) disable iff (rst)
        step |-> (rem_q < modulus));
endmodule

// File: rtl/modred_unit.sv
`timescale 1ns/1ps
module modred_unit
    import modred_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    input  logic              start,
    output logic              done
);
    localparam int OB       = OP_WORDS * WORD_W;
    localparam int MB       = MOD_WORDS * WORD_W;
    localparam int MOD_BASE = OP_BASE + OP_WORDS;
    localparam int RES_BASE = MOD_BASE + MOD_WORDS;

    logic [OB-1:0] operand;
    logic [MB-1:0] modulus;
    logic [MB-1:0] result;
    mode_e         mode;
    stat_t         stat;
    logic          mode_clr, mode_set, load, zero_res, step, last;

    assign mode_clr = wr_en && wr_addr == ADDR_W'(MODE_OFS) && wr_data == WORD_W'(CODE_RESET);
    assign mode_set = wr_en && wr_addr == ADDR_W'(MODE_OFS) && wr_data == WORD_W'(CODE_COMPUTE);

    modred_regfile #(.W(WORD_W), .OPW(OP_WORDS), .MDW(MOD_WORDS), .AW(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .lock(stat.busy), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .operand(operand), .modulus(modulus)
    );

    modred_ctrl #(.OP_BITS(OB), .WAIT(RESET_WAIT)) u_ctrl (
        .clk(clk), .rst(rst), .mode_clr(mode_clr), .mode_set(mode_set), .start(start),
        .mod_zero(modulus == '0), .mode(mode), .stat(stat), .done(done), .load(load),
        .zero_res(zero_res), .step(step), .last(last)
    );

    modred_core #(.OB(OB), .MB(MB)) u_core (
        .clk(clk), .rst(rst), .clear(mode_clr), .zero_res(zero_res), .load(load),
        .step(step), .last(last), .operand(operand), .modulus(modulus), .result(result)
    );

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(MODE_OFS))
            rd_data = {{(WORD_W-1){1'b0}}, mode};
        else if (rd_addr == ADDR_W'(STAT_OFS))
            rd_data = {{(WORD_W-3){1'b0}}, stat};
        for (int i = 0; i < OP_WORDS; i++)
            if (rd_addr == ADDR_W'(OP_BASE + i))
                rd_data = operand[word_lsb(i, OP_WORDS, WORD_W) +: WORD_W];
        for (int i = 0; i < MOD_WORDS; i++) begin
            if (rd_addr == ADDR_W'(MOD_BASE + i))
                rd_data = modulus[word_lsb(i, MOD_WORDS, WORD_W) +: WORD_W];
            if (rd_addr == ADDR_W'(RES_BASE + i))
                rd_data = result[word_lsb(i, MOD_WORDS, WORD_W) +: WORD_W];
        end
    end

    // R8: an error always comes with a cleared result
    a_r8_error_zero_result: assert property (@(posedge clk) disable iff (rst)
        stat.error |-> (result == '0));
    // R11: error and busy never hold together
    a_r11_error_not_busy: assert property (@(posedge clk) disable iff (rst)
        !(stat.error && stat.busy));
endmodule

// File: tb/tb_modred_unit.sv
`timescale 1ns/1ps
module tb_modred_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        start = 1'b0;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;

    always #2 clk = ~clk;

    modred_unit dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .start(start), .done(done)
    );

    always @(posedge clk) if (!rst && done) done_cnt++;

    task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = 6'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        rd_addr = 6'(a);
        #1;
        d = rd_data;
    endtask

    task automatic load(input logic [511:0] op, input logic [255:0] md);
        for (int i = 0; i < 16; i++) wr(2 + i, op[(15 - i) * 32 +: 32]);
        for (int i = 0; i < 8; i++)  wr(18 + i, md[(7 - i) * 32 +: 32]);
    endtask

    task automatic get_result(output logic [255:0] r);
        logic [31:0] d;
        for (int i = 0; i < 8; i++) begin
            rd(26 + i, d);
            r[(7 - i) * 32 +: 32] = d;
        end
    endtask

    task automatic run(output int lat);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 2000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    function automatic logic [255:0] ref_mod(input logic [511:0] op, input logic [255:0] md);
        logic [511:0] wide;
        wide = op % {256'b0, md};
        return wide[255:0];
    endfunction

    task automatic full_case(input string req, input logic [511:0] op, input logic [255:0] md);
        int lat;
        logic [255:0] r;
        load(op, md);
        run(lat);
        check({req, " latency"}, 512'(lat), 512'd512);
        get_result(r);
        check(req, 512'(r), 512'(ref_mod(op, md)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0]  d;
        logic [255:0] r;
        logic [511:0] op;
        logic [255:0] md;
        int lat;
        int base_done;
        void'($urandom(32'd2024));

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: reset state
        for (int a = 0; a < 34; a++) begin
            rd(a, d);
            check("R2 reset word", 512'(d), 512'd0);
        end
        check("R2 done low", 512'(done), 512'd0);

        // R5: start before the ready handshake is ignored
        wr(0, 1);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (3) @(negedge clk);
        rd(1, d);
        check("R5 no busy before ready", 512'(d), 512'd0);
        check("R5 no done before ready", 512'(done_cnt), 512'd0);

        // R3: reset handshake, ready 4 cycles after write edge
        wr(0, 0);
        lat = 0;
        rd(1, d);
        while (d[0] == 1'b0 && lat < 100) begin
            @(negedge clk); lat++;
            rd(1, d);
        end
        check("R3 ready latency", 512'(lat), 512'd4);
        check("R3 status ready", 512'(d), 512'd1);

        // R4: only codes 0 and 1 accepted
        wr(0, 5);
        rd(0, d);
        check("R4 illegal code ignored", 512'(d), 512'd0);
        wr(0, 1);
        rd(0, d);
        check("R4 compute code", 512'(d), 512'd1);
        wr(0, 2);
        rd(0, d);
        check("R4 illegal code keeps compute", 512'(d), 512'd1);

        // R6 R7: fixed vectors
        op = 512'h2c6c3246fcedb0546f969b8619d03bf8e16b88ca7b31acf2c800afa8c1945fa12719c7f1c7c99bb7;
        md = 256'he5d8c140e15a3be238d81bd77229b1b8008a143d;
        load(op, md);
        run(lat);
        check("R7 latency", 512'(lat), 512'd512);
        @(negedge clk);
        check("R7 done single pulse", 512'(done), 512'd0);
        get_result(r);
        check("R6 vector A", 512'(r), 512'h5ba7b73f60c6fa9487a618586350a9025c1713ae);

        op = 512'hfea54c798eac6e6a78f14231687faea7865fac876e8a7f6a76e5afa9c87fe87a56b9a87e18756ffe;
        md = 256'd3;
        load(op, md);
        run(lat);
        get_result(r);
        check("R6 mod three", 512'(r), 512'd2);

        // R1: word order and unmapped read
        rd(8, d);
        check("R1 operand word 6 is top nonzero word", 512'(d), 512'hfea54c79);
        rd(25, d);
        check("R1 modulus word 7 least significant", 512'(d), 512'd3);
        rd(40, d);
        check("R1 unmapped reads zero", 512'(d), 512'd0);

        // R10: status and result words are read-only
        wr(1, 32'h7);
        rd(1, d);
        check("R10 status unchanged", 512'(d), 512'd1);
        wr(33, 32'hdead);
        rd(33, d);
        check("R10 result unchanged", 512'(d), 512'd2);

        // R9 R7 R5: lockout and second start while busy
        op = {16{32'h89abcdef}};
        md = {32'h0, {7{32'h13572468}}};
        load(op, md);
        base_done = done_cnt;
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (10) @(negedge clk);
        rd(1, d);
        check("R7 busy while running", 512'(d), 512'd3);
        wr(2, 32'h0);
        wr(19, 32'h1);
        start = 1'b1; @(negedge clk); start = 1'b0;
        lat = 13;
        while (!done && lat < 2000) begin
            @(negedge clk); lat++;
        end
        check("R5 second start ignored, latency", 512'(lat), 512'd512);
        repeat (3) @(negedge clk);
        check("R5 single done", 512'(done_cnt - base_done), 512'd1);
        rd(2, d);
        check("R9 operand write ignored", 512'(d), 512'h89abcdef);
        rd(19, d);
        check("R9 modulus write ignored", 512'(d), 512'h13572468);
        get_result(r);
        check("R9 result intact", 512'(r), 512'(ref_mod(op, md)));

        // R8: zero modulus
        load(op, 256'd0);
        run(lat);
        check("R8 immediate done", 512'(lat), 512'd0);
        rd(1, d);
        check("R8 error bit", 512'(d), 512'd5);
        get_result(r);
        check("R8 result zero", 512'(r), 512'd0);

        // R11: next good run clears error
        full_case("R11 run after error", op, 256'd12345);
        rd(1, d);
        check("R11 error cleared", 512'(d), 512'd1);

        // R3: mode reset clears result and error
        wr(0, 0);
        get_result(r);
        check("R3 result cleared", 512'(r), 512'd0);
        rd(1, d);
        check("R3 status cleared", 512'(d), 512'd0);
        repeat (6) @(negedge clk);
        wr(0, 1);

        // R6 corners
        full_case("R6 operand below modulus", 512'h1234, 256'h1_0000_0000_0000);
        full_case("R6 modulus one", {16{32'hffffffff}}, 256'd1);
        full_case("R6 all ones", {16{32'hffffffff}}, {8{32'hffffffff}});
        full_case("R6 top bit modulus", {16{32'h5a5a5a5a}}, {1'b1, 255'd7});

        // R6: constrained random
        for (int n = 0; n < 12; n++) begin
            for (int i = 0; i < 16; i++) op[i * 32 +: 32] = $urandom;
            for (int i = 0; i < 8; i++)  md[i * 32 +: 32] = $urandom;
            if (n % 2 == 0) op[511:320] = '0;
            if (n % 3 == 0) md[255:128] = '0;
            if (md == '0) md = 256'd9;
            full_case("R6 random", op, md);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule